// File: doc/BRIEF.md
# Signed Right Shift Unit with Status Flags

This block shifts an 8-, 16- or 32-bit operand right by a variable amount while filling the vacated high positions with copies of the operand's sign bit. It also computes the arithmetic status flags that a general-purpose processor's execute stage expects from such a shift. The caller supplies the operand, a size code, an 8-bit shift amount, the incoming flag word and two mode inputs. The first mode input marks the shift as the fixed shift-by-one form. The second selects a legacy mode in which the whole 8-bit amount is honoured. In normal mode only the low 5 bits of the amount are used.

Results are registered. A `start` pulse captures the new result and flags at the next rising clock edge, and `done` rises in that same cycle. When `start` is low, the outputs keep their last values. Because the shift rounds toward negative infinity, the block is a floor division of a signed number by a power of two.

The flag word keeps each flag at a fixed bit position: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow.

Top module: `sar_shift_unit`

## Requirements
- R1: For an effective count n with 0 < n < W (W is the operand width), the low W bits of `result` equal the operand's low W bits shifted right by n, with copies of operand bit W-1 filling the top n positions. Bits of `result` above W are 0.
- R2: For a nonzero effective count, carry (flag bit 0) equals the last bit shifted out of the low end, which is operand bit n-1 when n <= W.
- R3: For a nonzero effective count, overflow (flag bit 5) is 0 when `one_form` is 1. Otherwise it keeps its incoming value.
- R4: When `legacy` is 0, the effective count is `count[4:0]`. When `legacy` is 1, it is all 8 bits of `count`.
- R5: `size_sel` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 select 32 bits. Operand bits above the selected width never affect the outputs.
- R6: For an effective count of W or more, the low W bits of `result` are all copies of operand bit W-1, and carry equals that bit.
- R7: For an effective count of 0, `result` equals the operand's low W bits and `flags_out` equals `flags_in` unchanged.
- R8: For a nonzero effective count, sign (bit 4) equals `result` bit W-1, and zero (bit 3) is 1 exactly when `result` is 0.
- R9: For a nonzero effective count, parity (bit 1) is 1 when `result[7:0]` holds an even number of ones.
- R10: Auxiliary carry (bit 2) is always copied from `flags_in` bit 2.
- R11: `done` is 1 in the cycle after a clock edge with `start` high and 0 otherwise. While `start` is low, `result` and `flags_out` hold their values.
- R12: A clock edge with `rst` high clears `result`, `flags_out` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture a new shift at this edge |
| operand | input | 32 | Value to shift, right-aligned to the selected width |
| size_sel | input | 2 | Operand width code (00=8, 01=16, 1x=32) |
| count | input | 8 | Requested shift amount |
| one_form | input | 1 | Shift is the fixed shift-by-one form |
| legacy | input | 1 | Use all 8 count bits instead of the low 5 |
| flags_in | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| result | output | 32 | Registered shifted value, zero above the width |
| flags_out | output | 6 | Registered updated flags, same layout |
| done | output | 1 | High one cycle after a start |

## Verification
The bench sweeps every count from 0 to 255 in both modes for each of the four size codes. The operands are zero, all ones, the most negative value, the most positive value and two mixed patterns carrying junk above the 8- and 16-bit widths. Zero and all-ones separate a correct sign fill from a logical shift. The extreme values and the junk bits expose width leakage and errors in the carry bit index. Counts of 32 and above tell the 5-bit mask apart from the legacy path, and counts at or above the width reach the saturation case. Idle cycles with changed inputs and a mid-run reset cover the hold and clear behaviour.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int FLAG_W = 6;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } size_e;
endpackage

// File: rtl/sar_count_sel.sv
module sar_count_sel #(
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic [CNT_W-1:0] count,
  input  logic             legacy,
  output logic [CNT_W-1:0] eff
);
  localparam int PAD_W = CNT_W - MASK_W;

  always_comb begin
    if (legacy) eff = count;
    else        eff = {{PAD_W{1'b0}}, count[MASK_W-1:0]};
  end

  always_comb begin
    if (!legacy) begin
      // R4: normal mode never sees an amount beyond the masked range
      p_mask_range_r4: assert (eff < CNT_W'(1 << MASK_W));
    end
  end
endmodule

// File: rtl/sar_shift_core.sv
module sar_shift_core #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int NUM_SIZES = 3,
  parameter int MIN_W     = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        size_sel,
  input  logic [CNT_W-1:0]  eff,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              sign
);
  logic [DATA_W-1:0] res_arr [NUM_SIZES];
  logic              cry_arr [NUM_SIZES];
  logic              sgn_arr [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int W    = MIN_W << s;
    localparam int SH_W = $clog2(W) + 1;
    logic [2*W-1:0]  ext;
    logic [SH_W-1:0] sat;
    logic [W-1:0]    sh;

    always_comb begin
      ext = {{W{operand[W-1]}}, operand[W-1:0]};
      sat = (eff >= CNT_W'(W)) ? SH_W'(W) : SH_W'(eff);
      sh  = W'(ext >> sat);
      res_arr[s] = DATA_W'(sh);
      cry_arr[s] = ext[sat - 1'b1];
      sgn_arr[s] = sh[W-1];
    end
  end

  logic [1:0] idx;
  always_comb begin
    idx    = (int'(size_sel) >= NUM_SIZES) ? 2'(NUM_SIZES - 1) : size_sel;
    result = res_arr[idx];
    carry  = cry_arr[idx];
    sign   = sgn_arr[idx];
  end
endmodule

// File: rtl/sar_flag_gen.sv
module sar_flag_gen
  import sar_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              eff_zero,
  input  logic              one_form,
  input  logic              carry,
  input  logic              sign,
  input  logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_nx
);
  always_comb begin
    flags_nx = flags_in;
    if (!eff_zero) begin
      flags_nx[FLG_CF] = carry;
      flags_nx[FLG_PF] = ~^result[7:0];
      flags_nx[FLG_ZF] = (result == '0);
      flags_nx[FLG_SF] = sign;
      flags_nx[FLG_OF] = one_form ? 1'b0 : flags_in[FLG_OF];
    end
  end
endmodule

// File: rtl/sar_shift_unit.sv
module sar_shift_unit
  import sar_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int MASK_W    = 5,
  parameter int NUM_SIZES = 3,
  parameter int MIN_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        size_sel,
  input  logic [CNT_W-1:0]  count,
  input  logic              one_form,
  input  logic              legacy,
  input  logic [5:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags_out,
  output logic              done
);
  logic [CNT_W-1:0]  eff;
  logic [DATA_W-1:0] res_nx;
  logic              cry_nx;
  logic              sgn_nx;
  logic [FLAG_W-1:0] flg_nx;

  sar_count_sel #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_cnt (
    .count(count), .legacy(legacy), .eff(eff)
  );

  sar_shift_core #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_SIZES(NUM_SIZES), .MIN_W(MIN_W)
  ) u_core (
    .operand(operand), .size_sel(size_sel), .eff(eff),
    .result(res_nx), .carry(cry_nx), .sign(sgn_nx)
  );

  sar_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .flags_in(flags_in), .eff_zero(eff == '0), .one_form(one_form),
    .carry(cry_nx), .sign(sgn_nx), .result(res_nx), .flags_nx(flg_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result    <= res_nx;
        flags_out <= flg_nx;
      end
    end
  end

  p_clear_r12: assert property (@(posedge clk)
    rst |=> (!done && result == '0 && flags_out == '0));

  p_done_r11: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && $stable(result) && $stable(flags_out)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (start && one_form && eff != '0) |=> !flags_out[FLG_OF]);

  p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
    (start && eff == '0) |=> flags_out == $past(flags_in));

  p_aux_pass_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> flags_out[FLG_AF] == $past(flags_in[FLG_AF]));

  p_byte_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (start && size_sel == SZ_BYTE && eff >= CNT_W'(MIN_W))
      |=> result == DATA_W'({MIN_W{$past(operand[MIN_W-1])}}));
endmodule

// File: tb/tb_sar_shift_unit.sv
module tb_sar_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  size_sel = '0;
  logic [7:0]  count = '0;
  logic        one_form = 1'b0;
  logic        legacy = 1'b0;
  logic [5:0]  flags_in = '0;
  logic [31:0] result;
  logic [5:0]  flags_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sar_shift_unit dut (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .size_sel(size_sel), .count(count), .one_form(one_form),
    .legacy(legacy), .flags_in(flags_in), .result(result),
    .flags_out(flags_out), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (size %0d cnt %0d legacy %0d op %h)",
               tag, act, exp, size_sel, count, legacy, operand);
    end
  endtask

  logic [31:0] e_res;
  logic [5:0]  e_flg;
  int          e_eff;
  int          e_w;

  task automatic model();
    longint v, r, mask;
    e_w   = (size_sel == 2'b00) ? 8 : (size_sel == 2'b01) ? 16 : 32;
    e_eff = legacy ? int'(count) : int'(count) % 32;
    mask  = (longint'(1) << e_w) - 1;
    v = longint'(operand) & mask;
    if (v >= (longint'(1) << (e_w - 1))) v = v - (longint'(1) << e_w);
    e_flg = flags_in;
    if (e_eff == 0) begin
      e_res = 32'(v & mask);
    end else begin
      r = v >>> e_eff;
      e_res = 32'(r & mask);
      e_flg[0] = 1'(((v >>> (e_eff - 1)) & 1));
      if (one_form) e_flg[5] = 1'b0;
      e_flg[4] = e_res[e_w-1];
      e_flg[3] = (e_res == 0);
      e_flg[1] = ~^e_res[7:0];
    end
  endtask

  task automatic run_op(input logic [31:0] op, input logic [1:0] sz,
                        input logic [7:0] cnt, input bit lg, input bit one,
                        input logic [5:0] fin);
    string rtag;
    operand = op; size_sel = sz; count = cnt; legacy = lg;
    one_form = one; flags_in = fin; start = 1'b1;
    model();
    @(negedge clk);
    if (e_eff == 0)          rtag = "R7 result";
    else if (e_eff >= e_w)   rtag = "R6 result";
    else if (!lg && cnt >= 32) rtag = "R4 result";
    else if (sz == 2'b11)    rtag = "R5 result";
    else                     rtag = "R1 result";
    check(result === e_res, rtag, result, e_res);
    check(flags_out[0] === e_flg[0], (e_eff == 0) ? "R7 carry" : "R2 carry",
          32'(flags_out[0]), 32'(e_flg[0]));
    check(flags_out[5] === e_flg[5], "R3 overflow", 32'(flags_out[5]), 32'(e_flg[5]));
    check(flags_out[4:3] === e_flg[4:3], "R8 sign/zero", 32'(flags_out[4:3]), 32'(e_flg[4:3]));
    check(flags_out[1] === e_flg[1], "R9 parity", 32'(flags_out[1]), 32'(e_flg[1]));
    check(flags_out[2] === e_flg[2], "R10 aux", 32'(flags_out[2]), 32'(e_flg[2]));
    check(done === 1'b1, "R11 done", 32'(done), 32'd1);
  endtask

  logic [31:0] ops [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                           32'h7FFF_FFFF, 32'h5A3C_81F7, 32'hC3E1_7F80};

  initial begin
    logic [31:0] held_r;
    logic [5:0]  held_f;
    @(negedge clk);
    @(negedge clk);
    check(result === '0 && flags_out === '0 && done === 1'b0, "R12 reset",
          result, 32'd0);
    rst = 1'b0;

    // Boundary operands per width: most negative and most positive of each size
    run_op(32'h0000_0080, 2'b00, 8'd1, 1'b0, 1'b1, 6'h3F);
    check(result === 32'h0000_00C0, "R1 byte min", result, 32'h0000_00C0);
    run_op(32'h0000_00FF, 2'b00, 8'd1, 1'b0, 1'b1, 6'h00);
    check(result === 32'h0000_00FF, "R1 floor -1", result, 32'h0000_00FF);
    run_op(32'hFFFF_7FFF, 2'b01, 8'd15, 1'b0, 1'b0, 6'h20);
    check(result === 32'h0000_0000 && flags_out[0] === 1'b1, "R2 half max",
          result, 32'd0);

    for (int sz = 0; sz < 4; sz++) begin
      for (int lg = 0; lg < 2; lg++) begin
        for (int c = 0; c < 256; c++) begin
          for (int o = 0; o < 6; o++) begin
            run_op(ops[o], 2'(sz), 8'(c), lg[0], (((c ^ o) & 3) == 1),
                   6'((c * 7 + o * 13 + sz) & 63));
          end
        end
      end
    end

    // Idle: inputs change but outputs must hold, done low
    run_op(32'h0000_1234, 2'b01, 8'd3, 1'b0, 1'b0, 6'h15);
    held_r = result; held_f = flags_out;
    start = 1'b0; operand = 32'hDEAD_BEEF; count = 8'd7; flags_in = 6'h2A;
    @(negedge clk);
    check(result === held_r, "R11 hold result", result, held_r);
    check(flags_out === held_f, "R11 hold flags", 32'(flags_out), 32'(held_f));
    check(done === 1'b0, "R11 done low", 32'(done), 32'd0);

    // Mid-run reset
    run_op(32'hFFFF_FFFF, 2'b10, 8'd4, 1'b0, 1'b0, 6'h3F);
    rst = 1'b1; start = 1'b0;
    @(negedge clk);
    check(result === '0 && flags_out === '0 && done === 1'b0, "R12 mid reset",
          result, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule